// File: doc/BRIEF.md
# Miller-Rabin Primality Tester

This block decides whether an odd 32-bit candidate is a probable prime. A candidate arrives with a one-cycle start pulse. The block first splits the candidate minus one into a power of two and an odd part. It then runs a fixed number of test rounds. Each round asks an outside random source for a raw value over a request/acknowledge pair. It maps that value into the legal base range and runs one strong-pseudoprime round using its own sequential modular arithmetic.

The modular arithmetic rests on one shift-and-add modular multiplier. That multiplier is shared by three jobs: bringing the base into range, the right-to-left square-and-multiply exponentiation, and the follow-up squarings. The first round that exposes a witness ends the test at once. A one-cycle done pulse then carries the verdict. Callers are expected to filter out even numbers before they reach the block.

Top module: `mr_prime_tester`

## Requirements
- R1: After reset, done, prime and base_req are all 0.
- R2: Before the first round, n-1 is split as 2^s * d with d odd, where s is the number of trailing zero bits of n-1.
- R3: Each round takes one raw value base_raw from the port and uses the base a = 2 + (base_raw mod (n-3)), so 2 <= a <= n-2.
- R4: A round passes at once when a^d mod n equals 1 or n-1.
- R5: Otherwise x is squared modulo n at most s-1 times. Reaching n-1 passes the round. Reaching 1 gives composite. Using up the squarings without reaching either value gives composite.
- R6: A composite verdict ends the test immediately. No further base is requested, so the number of base requests equals the number of rounds run.
- R7: prime is 1 only after all ROUNDS rounds (default 4) pass, which takes exactly ROUNDS base requests. The candidate 2750263 ends with prime = 1.
- R8: For n = 3 the block reports prime = 1 without requesting any base, with done one cycle after start.
- R9: done is high for exactly one cycle. prime is valid with it and keeps its value until the next done.
- R10: A start pulse while a test is running is ignored, and the running test finishes with its own candidate.
- R11: The block holds base_req high until base_ack arrives, however late. A base_ack without a pending request has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that launches a test of n_in when idle |
| n_in | input | 32 | Odd candidate, at least 3 |
| base_req | output | 1 | High while the block waits for a raw random value |
| base_ack | input | 1 | Raw value on base_raw is valid this cycle |
| base_raw | input | 32 | Raw random value, any 32-bit pattern |
| done | output | 1 | One-cycle pulse, verdict valid |
| prime | output | 1 | 1 = probable prime, 0 = composite |

## Verification
The vector set covers four kinds of candidate. Candidates with s = 1 use no squarings at all, so a design that squares once too often would call primes such as 7 composite. Candidates with many trailing zeros, such as 97 and 561, exercise the squaring loop; an off-by-one there shows up as a Carmichael number passing or a prime failing. The largest 32-bit prime drives the multiplier to full width, where a missed reduction or a carry lost in the adder turns a prime composite. The bench counts base requests against an independent model, so a tester that keeps running after a failed round, or maps the raw value with a different modulus, is caught. Separate tests cover n = 3, a late acknowledge, a stray acknowledge while idle, and a second start during a run; a design that mishandles any of these returns the wrong verdict, the wrong request count, or a spurious done.

// File: rtl/mr_pkg.sv
package mr_pkg;
    typedef enum logic [3:0] {
        S_IDLE,
        S_SPLIT,
        S_REQ,
        S_RED,
        S_EXP,
        S_EXPM,
        S_EXPS,
        S_CHK,
        S_SQR
    } mr_state_e;
endpackage

// File: rtl/mr_split.sv
// Strips trailing zero bits: v = 2^s * d with d odd (v nonzero).
module mr_split #(
    parameter int W  = 32,
    localparam int SW = $clog2(W)
) (
    input  logic [W-1:0]  v_i,
    output logic [W-1:0]  d_o,
    output logic [SW-1:0] s_o
);
    logic found;

    always_comb begin
        s_o   = '0;
        found = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (!found && v_i[i]) begin
                s_o   = SW'(i);
                found = 1'b1;
            end
        end
        d_o = v_i >> s_o;
    end
endmodule

// File: rtl/mr_modmul.sv
// Sequential shift-add modular multiplier: res = (x * y) mod m.
// x is scanned MSB first and may be any value; y must be below m.
module mr_modmul #(
    parameter int W  = 32,
    localparam int CW = $clog2(W + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go_i,
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic [W-1:0] m_i,
    output logic         done_o,
    output logic [W-1:0] res_o
);
    typedef struct packed {
        logic          busy;
        logic          done;
        logic [CW-1:0] cnt;
        logic [W-1:0]  x;
        logic [W-1:0]  y;
        logic [W-1:0]  m;
        logic [W-1:0]  acc;
    } mm_t;

    mm_t q, d;
    logic [W:0] t1, t2;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        t1     = '0;
        t2     = '0;
        if (!q.busy) begin
            if (go_i) begin
                d.busy = 1'b1;
                d.cnt  = CW'(W);
                d.x    = x_i;
                d.y    = y_i;
                d.m    = m_i;
                d.acc  = '0;
            end
        end else begin
            t1 = {q.acc, 1'b0};
            if (t1 >= {1'b0, q.m}) t1 = t1 - {1'b0, q.m};
            t2 = t1 + (q.x[W-1] ? {1'b0, q.y} : '0);
            if (t2 >= {1'b0, q.m}) t2 = t2 - {1'b0, q.m};
            d.acc = t2[W-1:0];
            d.x   = q.x << 1;
            d.cnt = q.cnt - 1'b1;
            if (q.cnt == CW'(1)) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done_o = q.done;
    assign res_o  = q.acc;

    // R3: every product or reduction comes out below its modulus
    p_res_below_mod_r3: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> (q.acc < q.m));
endmodule

// File: rtl/mr_prime_tester.sv
module mr_prime_tester #(
    parameter int WIDTH  = 32,
    parameter int ROUNDS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] n_in,
    output logic             base_req,
    input  logic             base_ack,
    input  logic [WIDTH-1:0] base_raw,
    output logic             done,
    output logic             prime
);
    import mr_pkg::*;

    localparam int SW = $clog2(WIDTH);
    localparam int RW = $clog2(ROUNDS + 1);

    typedef struct packed {
        mr_state_e        st;
        logic [WIDTH-1:0] n;
        logic [WIDTH-1:0] d;
        logic [SW-1:0]    s;
        logic [SW-1:0]    sq;
        logic [WIDTH-1:0] e;
        logic [WIDTH-1:0] base;
        logic [WIDTH-1:0] x;
        logic [RW-1:0]    rnd;
        logic             done;
        logic             prime;
    } tst_t;

    tst_t q, nx;

    logic [WIDTH-1:0] nm1;
    logic [WIDTH-1:0] sp_d;
    logic [SW-1:0]    sp_s;
    logic             mul_go, mul_done;
    logic [WIDTH-1:0] mul_x, mul_y, mul_m, mul_res;

    assign nm1 = q.n - WIDTH'(1);

    mr_split #(.W(WIDTH)) split_i (
        .v_i (nm1),
        .d_o (sp_d),
        .s_o (sp_s)
    );

    mr_modmul #(.W(WIDTH)) mul_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (mul_go),
        .x_i    (mul_x),
        .y_i    (mul_y),
        .m_i    (mul_m),
        .done_o (mul_done),
        .res_o  (mul_res)
    );

    always_comb begin
        nx      = q;
        nx.done = 1'b0;
        mul_go  = 1'b0;
        mul_x   = '0;
        mul_y   = '0;
        mul_m   = q.n;
        case (q.st)
            S_IDLE: begin
                if (start) begin
                    nx.n   = n_in;
                    nx.rnd = '0;
                    if (n_in == WIDTH'(3)) begin
                        nx.done  = 1'b1;
                        nx.prime = 1'b1;
                    end else begin
                        nx.st = S_SPLIT;
                    end
                end
            end
            S_SPLIT: begin
                nx.d  = sp_d;
                nx.s  = sp_s;
                nx.st = S_REQ;
            end
            S_REQ: begin
                if (base_ack) begin
                    mul_go = 1'b1;
                    mul_x  = base_raw;
                    mul_y  = WIDTH'(1);
                    mul_m  = q.n - WIDTH'(3);
                    nx.st  = S_RED;
                end
            end
            S_RED: begin
                if (mul_done) begin
                    nx.base = mul_res + WIDTH'(2);
                    nx.x    = WIDTH'(1);
                    nx.e    = q.d;
                    nx.st   = S_EXP;
                end
            end
            S_EXP: begin
                if (q.e == '0) begin
                    nx.st = S_CHK;
                end else if (q.e[0]) begin
                    mul_go = 1'b1;
                    mul_x  = q.x;
                    mul_y  = q.base;
                    nx.st  = S_EXPM;
                end else begin
                    nx.e   = q.e >> 1;
                    mul_go = 1'b1;
                    mul_x  = q.base;
                    mul_y  = q.base;
                    nx.st  = S_EXPS;
                end
            end
            S_EXPM: begin
                if (mul_done) begin
                    nx.x    = mul_res;
                    nx.e[0] = 1'b0;
                    nx.st   = S_EXP;
                end
            end
            S_EXPS: begin
                if (mul_done) begin
                    nx.base = mul_res;
                    nx.st   = S_EXP;
                end
            end
            S_CHK: begin
                if (q.x == WIDTH'(1) || q.x == nm1) begin
                    if (q.rnd == RW'(ROUNDS - 1)) begin
                        nx.done  = 1'b1;
                        nx.prime = 1'b1;
                        nx.st    = S_IDLE;
                    end else begin
                        nx.rnd = q.rnd + 1'b1;
                        nx.st  = S_REQ;
                    end
                end else if (q.s == SW'(1)) begin
                    nx.done  = 1'b1;
                    nx.prime = 1'b0;
                    nx.st    = S_IDLE;
                end else begin
                    nx.sq  = q.s - 1'b1;
                    mul_go = 1'b1;
                    mul_x  = q.x;
                    mul_y  = q.x;
                    nx.st  = S_SQR;
                end
            end
            S_SQR: begin
                if (mul_done) begin
                    nx.x = mul_res;
                    if (mul_res == nm1) begin
                        if (q.rnd == RW'(ROUNDS - 1)) begin
                            nx.done  = 1'b1;
                            nx.prime = 1'b1;
                            nx.st    = S_IDLE;
                        end else begin
                            nx.rnd = q.rnd + 1'b1;
                            nx.st  = S_REQ;
                        end
                    end else if (mul_res == WIDTH'(1) || q.sq == SW'(1)) begin
                        nx.done  = 1'b1;
                        nx.prime = 1'b0;
                        nx.st    = S_IDLE;
                    end else begin
                        nx.sq  = q.sq - 1'b1;
                        mul_go = 1'b1;
                        mul_x  = mul_res;
                        mul_y  = mul_res;
                    end
                end
            end
            default: nx.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= S_IDLE;
        end else begin
            q <= nx;
        end
    end

    assign base_req = (q.st == S_REQ);
    assign done     = q.done;
    assign prime    = q.prime;

    // R2: the split held for the rounds is odd and rebuilds n-1
    p_split_odd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_REQ) |-> (q.d[0] && ((q.d << q.s) == nm1)));

    // R3: a freshly mapped base lies in [2, n-2]
    p_base_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(q.st) == S_RED && q.st == S_EXP) |->
            (q.base >= WIDTH'(2) && q.base <= q.n - WIDTH'(2)));

    // R7: the round index never reaches the round count
    p_round_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        q.rnd < RW'(ROUNDS));

    // R8: candidate 3 is reported prime on the next cycle
    p_three_prime_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_IDLE && start && n_in == WIDTH'(3)) |=> (done && prime));

    // R9: done never lasts two cycles
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: without start, an idle tester stays idle whatever base_ack does
    p_idle_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_IDLE && !start) |=> (q.st == S_IDLE && !done));
endmodule

// File: tb/mr_prime_tester_tb_top.sv
module mr_prime_tester_tb_top;
    localparam int W = 32;
    localparam int K = 4;
    localparam int NV = 12;
    localparam logic [31:0] VN [NV] = '{
        32'd5, 32'd7, 32'd9, 32'd15, 32'd97, 32'd121, 32'd561, 32'd2047,
        32'd65537, 32'd2750263, 32'd1000003, 32'd4294967291
    };
    localparam bit VP [NV] = '{
        1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0,
        1'b1, 1'b1, 1'b1, 1'b1
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [W-1:0] n_in = '0;
    logic base_req, base_ack, done, prime;
    logic ack_r = 1'b0;
    logic spur_ack = 1'b0;
    logic [W-1:0] raw_r = '0;

    int errors = 0;
    int checks = 0;
    int req_idx = 0;
    int stall = 0;
    int wait_cnt = 0;
    logic [31:0] raws [K];
    logic [31:0] seed = 32'h1234_5678;

    always #4 clk = ~clk;

    assign base_ack = ack_r | spur_ack;

    mr_prime_tester #(.WIDTH(W), .ROUNDS(K)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .n_in     (n_in),
        .base_req (base_req),
        .base_ack (base_ack),
        .base_raw (raw_r),
        .done     (done),
        .prime    (prime)
    );

    // random source: answers each request, optionally after a stall
    always @(negedge clk) begin
        if (base_req && !ack_r) begin
            if (wait_cnt < stall) begin
                wait_cnt = wait_cnt + 1;
            end else begin
                ack_r    = 1'b1;
                raw_r    = raws[req_idx % K];
                req_idx  = req_idx + 1;
                wait_cnt = 0;
            end
        end else begin
            ack_r = 1'b0;
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint unsigned powmod(input longint unsigned a,
            input longint unsigned e, input longint unsigned m);
        longint unsigned r = 1;
        longint unsigned b = a % m;
        longint unsigned x = e;
        while (x != 0) begin
            if (x[0]) r = (r * b) % m;
            b = (b * b) % m;
            x = x >> 1;
        end
        return r;
    endfunction

    task automatic model(input longint unsigned n, output bit pr, output int rounds);
        longint unsigned dd, a, x;
        int s;
        bit pass;
        rounds = 0;
        pr = 1'b1;
        if (n == 3) return;
        dd = n - 1;
        s = 0;
        while (dd[0] == 1'b0) begin
            dd = dd >> 1;
            s = s + 1;
        end
        for (int r = 0; r < K; r++) begin
            a = 2 + (longint'(raws[r]) % (n - 3));
            x = powmod(a, dd, n);
            rounds = r + 1;
            pass = (x == 1) || (x == n - 1);
            for (int j = 1; j < s && !pass; j++) begin
                x = (x * x) % n;
                if (x == n - 1) pass = 1'b1;
                else if (x == 1) break;
            end
            if (!pass) begin
                pr = 1'b0;
                return;
            end
        end
    endtask

    task automatic fill_raws();
        for (int i = 0; i < K; i++) begin
            seed = seed ^ (seed << 13);
            seed = seed ^ (seed >> 17);
            seed = seed ^ (seed << 5);
            raws[i] = seed;
        end
    endtask

    // runs one candidate; intr_n nonzero injects a second start mid-run
    task automatic run_one(input logic [31:0] n, input bit exp_pr, input string tag,
                           input logic [31:0] intr_n);
        bit mpr;
        int mrounds;
        int cyc;
        bit got;
        fill_raws();
        model(longint'(n), mpr, mrounds);
        req_idx = 0;
        n_in  = n;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 50000) begin
            if (intr_n != 0 && cyc == 10) begin
                n_in  = intr_n;
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc = cyc + 1;
        end
        start = 1'b0;
        check(done == 1'b1, {tag, " done seen"}, longint'(done), 1);
        got = prime;
        check(got == exp_pr, {tag, " prime R4 R5 R7"}, longint'(got), longint'(exp_pr));
        check(req_idx == mrounds, {tag, " base requests R6"}, req_idx, mrounds);
        @(negedge clk);
        check(done == 1'b0 && prime == got, {tag, " done pulse R9"}, longint'(done), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors = errors + 1;
        checks = checks + 1;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        check(done == 1'b0 && prime == 1'b0 && base_req == 1'b0, "R1 reset outputs",
              longint'({done, prime, base_req}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            run_one(VN[v], VP[v], $sformatf("R2 R3 vector n=%0d", VN[v]), 32'd0);
        end

        // R8: n = 3 needs no base and finishes next cycle
        fill_raws();
        req_idx = 0;
        n_in  = 32'd3;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b1 && prime == 1'b1, "R8 n=3 verdict", longint'({done, prime}), 3);
        check(req_idx == 0, "R8 n=3 no base request", req_idx, 0);
        @(negedge clk);
        check(done == 1'b0, "R9 n=3 pulse", longint'(done), 0);

        // R11: stray acknowledge while idle has no effect
        spur_ack = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(done == 1'b0 && base_req == 1'b0, "R11 stray ack idle",
                  longint'({done, base_req}), 0);
        end
        spur_ack = 1'b0;
        @(negedge clk);

        // R11: late acknowledge
        stall = 7;
        run_one(32'd97, 1'b1, "R11 stalled ack n=97", 32'd0);
        run_one(32'd561, 1'b0, "R11 stalled ack n=561", 32'd0);
        stall = 0;

        // R10: a second start during a run is ignored
        run_one(32'd2750263, 1'b1, "R10 start ignored n=2750263", 32'd9);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule